// File: doc/BRIEF.md
# Doorbell Mailbox Controller

This block sits between a host register bus and the packet side of a serial interconnect endpoint. It handles short doorbell messages, each a 16-bit payload tagged with a device ID. A host write to the transmit register queues an outgoing doorbell. The packet side takes queued requests over a valid/ready stream and later reports, one status pulse per request and in issue order, whether each one completed or failed. Completions are logged in a completion queue that the host pops one entry per read. Incoming doorbells arrive on a second valid/ready stream and wait in a receive queue, which the host also pops one entry per read.

A single interrupt line combines three pending conditions, each gated by its own bit in a three-bit enable field. The conditions are a receive message waiting, a successful completion seen, and a failed completion seen. The parameter `LARGE_ID` selects 16-bit device IDs. When it is 0, IDs are 8 bits wide and the upper byte of every stored ID is forced to zero. All three queues and the in-flight tracker are `DEPTH` entries deep (16 by default).

Back-pressure rules are as follows. `tx_valid` is high while a request is queued and fewer than `DEPTH` requests await completion. Once `tx_valid` is high, it stays high and its data stays unchanged until `tx_ready` accepts the request. `rx_ready` is low while the receive queue is full, and a message is taken only in a cycle with `rx_valid && rx_ready`. The completion pulse cannot be back-pressured.

Top module: `dbell_mbox`

## Requirements
- R1: After reset, `tx_valid` is 0, `irq` is 0, `rx_ready` is 1, and all enables and sticky flags are clear.
- R2: Each write to offset 0x0C (payload in wdata[15:0], ID in wdata[31:16]) appears on `tx_payload`/`tx_dest` in write order. While `tx_valid` is high and `tx_ready` is low, the request holds unchanged.
- R3: With `LARGE_ID`=0, transmit and receive IDs keep only their low 8 bits, so an ID of 0xABCD becomes 0x00CD.
- R4: A transmit write that arrives while `DEPTH` requests are already queued is dropped and sets status bit 0 at offset 0x04. That bit is sticky until a 1 is written to it.
- R5: A read at offset 0x10 pops the oldest logged completion and returns valid at bit 33, error at bit 32, ID at [31:16] and payload at [15:0]. Completions are matched to requests in issue order.
- R6: Control bit 0 at offset 0x08 selects whether failed completions are logged. When it is 0, only successful completions are logged.
- R7: A read of an empty receive or completion queue returns all zeros, which includes a valid bit of 0.
- R8: A read at offset 0x00 pops the oldest received doorbell, using the same layout as R5 with the error bit at 0. `rx_ready` falls once `DEPTH` messages are held and rises again after a read.
- R9: `irq` is the OR of enable bit 0 with receive-not-empty, enable bit 1 with the success flag, and enable bit 2 with the failure flag. The enable field is at offset 0x20. The success and failure flags are sticky, set by completions, and cleared by writing 1 to status bits 1 and 2.
- R10: `tx_valid` stays low while `DEPTH` issued requests await completion, even if requests are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops for 0x00 and 0x10) |
| host_addr | input | 6 | Byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 34 | Read data, registered one cycle after `host_rd` |
| tx_valid | output | 1 | Outgoing doorbell request available |
| tx_ready | input | 1 | Packet side accepts the request |
| tx_payload | output | 16 | Outgoing payload |
| tx_dest | output | 16 | Outgoing destination ID |
| cpl_pulse | input | 1 | One-cycle completion report for the oldest issued request |
| cpl_err | input | 1 | Completion failed (qualified by `cpl_pulse`) |
| rx_valid | input | 1 | Incoming doorbell available |
| rx_ready | output | 1 | Receive queue has room |
| rx_payload | input | 16 | Incoming payload |
| rx_src | input | 16 | Incoming source ID |
| irq | output | 1 | Doorbell interrupt |

## Verification
The assertions take the following for granted about the inputs. `cpl_pulse` arrives only while at least one issued request is outstanding. The completion queue is never full when a logged completion arrives. `host_wr` and `host_rd` are never raised in the same cycle. The bench keeps within these limits. It reports completions only for requests its monitor has seen accepted. It reads each logged completion back before the queue could fill. It drives bus writes and reads from separate tasks that never overlap.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_RX   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_TX   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CPL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h20;

  typedef struct packed {
    logic [15:0] id;
    logic [15:0] payload;
  } msg_t;

  typedef struct packed {
    logic err;
    msg_t msg;
  } cpl_t;
endpackage

// File: rtl/dbell_fifo.sv
module dbell_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= wdata;
  end

  assign rdata = mem[rptr[AW-1:0]];
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
endmodule

// File: rtl/dbell_irq.sv
module dbell_irq #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] pending,
  output logic            irq
);
  assign irq = |(enable & pending);
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
  import dbell_pkg::*;
#(
  parameter bit LARGE_ID = 1'b0,
  parameter int DEPTH    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [33:0]       host_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [15:0]       tx_payload,
  output logic [15:0]       tx_dest,
  input  logic              cpl_pulse,
  input  logic              cpl_err,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [15:0]       rx_payload,
  input  logic [15:0]       rx_src,
  output logic              irq
);
  localparam logic [15:0] ID_MASK = LARGE_ID ? 16'hFFFF : 16'h00FF;
  localparam int MSG_W = $bits(msg_t);
  localparam int CPL_W = $bits(cpl_t);

  // sticky flags and configuration
  logic       ovf_q, ok_pend, err_pend, log_fail;
  logic [2:0] irq_en;

  // queue interfaces
  msg_t txq_in, txq_head, infl_head, rxq_in, rxq_head;
  cpl_t cplq_in, cplq_head;
  logic txq_empty, txq_full, infl_empty, infl_full;
  logic cplq_empty, cplq_full, rxq_empty, rxq_full;
  logic txq_push, tx_fire, infl_pop, cplq_push, rxq_push;
  logic rd_rx, rd_cpl, wr_tx, wr_stat;

  assign wr_tx   = host_wr && (host_addr == OFS_TX);
  assign wr_stat = host_wr && (host_addr == OFS_STAT);
  assign rd_rx   = host_rd && (host_addr == OFS_RX);
  assign rd_cpl  = host_rd && (host_addr == OFS_CPL);

  // transmit side
  assign txq_in   = '{id: host_wdata[31:16] & ID_MASK, payload: host_wdata[15:0]};
  assign txq_push = wr_tx && !txq_full;
  assign tx_valid = !txq_empty && !infl_full;
  assign tx_fire  = tx_valid && tx_ready;
  assign tx_payload = txq_head.payload;
  assign tx_dest    = txq_head.id;

  // completion side
  assign infl_pop  = cpl_pulse && !infl_empty;
  assign cplq_in   = '{err: cpl_err, msg: infl_head};
  assign cplq_push = infl_pop && (!cpl_err || log_fail);

  // receive side
  assign rx_ready = !rxq_full;
  assign rxq_push = rx_valid && rx_ready;
  assign rxq_in   = '{id: rx_src & ID_MASK, payload: rx_payload};

  dbell_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(txq_push), .wdata(txq_in),
    .pop(tx_fire), .rdata(txq_head), .empty(txq_empty), .full(txq_full));

  dbell_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_infl (
    .clk(clk), .rst_n(rst_n), .push(tx_fire), .wdata(txq_head),
    .pop(infl_pop), .rdata(infl_head), .empty(infl_empty), .full(infl_full));

  dbell_fifo #(.W(CPL_W), .DEPTH(DEPTH)) u_cplq (
    .clk(clk), .rst_n(rst_n), .push(cplq_push), .wdata(cplq_in),
    .pop(rd_cpl), .rdata(cplq_head), .empty(cplq_empty), .full(cplq_full));

  dbell_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rxq_push), .wdata(rxq_in),
    .pop(rd_rx), .rdata(rxq_head), .empty(rxq_empty), .full(rxq_full));

  // control registers and sticky flags (set wins over clear)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q    <= 1'b0;
      ok_pend  <= 1'b0;
      err_pend <= 1'b0;
      log_fail <= 1'b0;
      irq_en   <= '0;
    end else begin
      if (wr_tx && txq_full)                 ovf_q <= 1'b1;
      else if (wr_stat && host_wdata[0])     ovf_q <= 1'b0;
      if (infl_pop && !cpl_err)              ok_pend <= 1'b1;
      else if (wr_stat && host_wdata[1])     ok_pend <= 1'b0;
      if (infl_pop && cpl_err)               err_pend <= 1'b1;
      else if (wr_stat && host_wdata[2])     err_pend <= 1'b0;
      if (host_wr && host_addr == OFS_CTRL)  log_fail <= host_wdata[0];
      if (host_wr && host_addr == OFS_IEN)   irq_en <= host_wdata[2:0];
    end
  end

  // registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        OFS_RX:   host_rdata <= rxq_empty ? '0 : {2'b10, rxq_head};
        OFS_STAT: host_rdata <= {30'd0, !rxq_empty, err_pend, ok_pend, ovf_q};
        OFS_CTRL: host_rdata <= {33'd0, log_fail};
        OFS_CPL:  host_rdata <= cplq_empty ? '0 : {1'b1, cplq_head};
        OFS_IEN:  host_rdata <= {31'd0, irq_en};
        default:  host_rdata <= '0;
      endcase
    end
  end

  dbell_irq #(.NSRC(3)) u_irq (
    .enable (irq_en),
    .pending({err_pend, ok_pend, !rxq_empty}),
    .irq    (irq));
endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk
  import dbell_pkg::*;
#(
  parameter bit LARGE_ID = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       host_wdata,
  input logic [33:0]       host_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [15:0]       tx_payload,
  input logic [15:0]       tx_dest,
  input logic              irq,
  input logic [2:0]        irq_en,
  input logic              ovf_q,
  input logic              cplq_empty,
  input logic              rxq_empty
);
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_payload) && $stable(tx_dest));

  a_r3_narrow_dest: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !LARGE_ID |-> tx_dest[15:8] == 8'd0);

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !(host_wr && host_addr == OFS_STAT && host_wdata[0]) |=> ovf_q);

  a_r7_cpl_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == OFS_CPL && cplq_empty |=> host_rdata == 34'd0);

  a_r7_rx_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == OFS_RX && rxq_empty |=> host_rdata == 34'd0);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en == 3'b000 |-> !irq);
endmodule

bind dbell_mbox dbell_mbox_chk #(.LARGE_ID(LARGE_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_payload(tx_payload),
  .tx_dest(tx_dest), .irq(irq), .irq_en(irq_en), .ovf_q(ovf_q),
  .cplq_empty(cplq_empty), .rxq_empty(rxq_empty));

// File: tb/test_dbell_mbox.sv
`timescale 1ns/1ps
module test_dbell_mbox;
  import dbell_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [33:0] host_rdata;
  logic tx_valid, tx_ready = 0, cpl_pulse = 0, cpl_err = 0;
  logic [15:0] tx_payload, tx_dest, rx_payload = '0, rx_src = '0;
  logic rx_valid = 0, rx_ready, irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_tx[$], exp_infl[$], exp_rx[$];
  logic [33:0] exp_cpl[$];
  logic log_fail_m = 1'b0;
  logic [31:0] mon_e;
  logic [33:0] rd;

  always #2 clk = ~clk;

  dbell_mbox i_dbell_mbox (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_payload(tx_payload),
    .tx_dest(tx_dest), .cpl_pulse(cpl_pulse), .cpl_err(cpl_err),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_payload(rx_payload),
    .rx_src(rx_src), .irq(irq));

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every accepted request must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) begin
        chk("R2 unexpected request", {2'b0, tx_dest, tx_payload}, 34'h3FFFFFFFF);
      end else begin
        mon_e = exp_tx.pop_front();
        chk("R2/R3 request order and id", {2'b0, tx_dest, tx_payload}, {2'b0, mon_e});
        exp_infl.push_back(mon_e);
      end
    end
  end

  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic host_read(input logic [ADDR_W-1:0] a, output logic [33:0] d);
    @(posedge clk); #1;
    host_rd = 1; host_addr = a;
    @(posedge clk); #1;
    host_rd = 0;
    d = host_rdata;
  endtask

  task automatic tx_send(input logic [15:0] p, input logic [15:0] id, input bit accepted);
    if (accepted) exp_tx.push_back({id & 16'h00FF, p});
    host_write(OFS_TX, {id, p});
  endtask

  task automatic complete(input logic err);
    logic [31:0] e;
    if (exp_infl.size() == 0) begin
      chk("R5 completion with nothing issued", 34'd1, 34'd0);
      e = '0;
    end else begin
      e = exp_infl.pop_front();
    end
    if (!err || log_fail_m) exp_cpl.push_back({1'b1, err, e});
    @(posedge clk); #1;
    cpl_pulse = 1; cpl_err = err;
    @(posedge clk); #1;
    cpl_pulse = 0; cpl_err = 0;
  endtask

  task automatic cpl_check(input string req);
    logic [33:0] d;
    host_read(OFS_CPL, d);
    chk(req, d, (exp_cpl.size() != 0) ? exp_cpl.pop_front() : 34'd0);
  endtask

  task automatic rx_send(input logic [15:0] p, input logic [15:0] s);
    exp_rx.push_back({s & 16'h00FF, p});
    @(posedge clk); #1;
    rx_valid = 1; rx_payload = p; rx_src = s;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic rx_check(input string req);
    logic [33:0] d;
    host_read(OFS_RX, d);
    chk(req, d, (exp_rx.size() != 0) ? {2'b10, exp_rx.pop_front()} : 34'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tx_valid after reset", {33'd0, tx_valid}, 34'd0);
    chk("R1 irq after reset", {33'd0, irq}, 34'd0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 rx_ready after reset", {33'd0, rx_ready}, 34'd1);
    host_read(OFS_STAT, rd);
    chk("R1 status after reset", rd, 34'd0);
    host_read(OFS_IEN, rd);
    chk("R1 enables after reset", rd, 34'd0);

    // five doorbells held back by the packet side
    host_write(OFS_CTRL, 32'd1);
    log_fail_m = 1'b1;
    for (int i = 0; i < 5; i++) tx_send(16'h0100 + 16'(i), 16'hABCD, 1'b1);
    @(negedge clk);
    chk("R2 tx_valid with queued requests", {33'd0, tx_valid}, 34'd1);
    chk("R3 narrow destination id", {18'd0, tx_dest}, 34'h000CD);
    @(posedge clk); #1; tx_ready = 1;
    repeat (8) @(posedge clk);
    #1; tx_ready = 0;
    chk("R2 all requests issued", 34'(exp_tx.size()), 34'd0);

    // mixed completions, failures logged
    complete(1'b0); complete(1'b0); complete(1'b1); complete(1'b0); complete(1'b1);
    for (int i = 0; i < 5; i++) cpl_check("R5 logged completion");
    cpl_check("R7 empty completion queue read");

    // failures not logged
    host_write(OFS_CTRL, 32'd0);
    log_fail_m = 1'b0;
    tx_send(16'h0200, 16'h0011, 1'b1);
    tx_send(16'h0201, 16'h0022, 1'b1);
    @(posedge clk); #1; tx_ready = 1;
    repeat (4) @(posedge clk);
    #1; tx_ready = 0;
    complete(1'b1); complete(1'b0);
    cpl_check("R6 only the successful completion");
    cpl_check("R6 failed completion not logged");

    // interrupt gating
    @(negedge clk);
    chk("R9 irq masked", {33'd0, irq}, 34'd0);
    host_write(OFS_IEN, 32'd2);
    chk("R9 irq on success flag", {33'd0, irq}, 34'd1);
    host_write(OFS_STAT, 32'd2);
    chk("R9 irq after success clear", {33'd0, irq}, 34'd0);
    host_write(OFS_IEN, 32'd4);
    chk("R9 irq on failure flag", {33'd0, irq}, 34'd1);
    host_write(OFS_STAT, 32'd4);
    chk("R9 irq after failure clear", {33'd0, irq}, 34'd0);

    // receive path
    host_write(OFS_IEN, 32'd1);
    chk("R9 irq with empty receive queue", {33'd0, irq}, 34'd0);
    rx_send(16'h5001, 16'h12AB);
    rx_send(16'h5002, 16'h0034);
    rx_send(16'h5003, 16'hFF56);
    chk("R9 irq on received message", {33'd0, irq}, 34'd1);
    for (int i = 0; i < 3; i++) rx_check("R8 received message order");
    chk("R9 irq after receive drained", {33'd0, irq}, 34'd0);
    for (int i = 0; i < 16; i++) rx_send(16'h6000 + 16'(i), 16'(i));
    @(negedge clk);
    chk("R8 rx_ready low when full", {33'd0, rx_ready}, 34'd0);
    rx_check("R8 pop from full queue");
    @(negedge clk);
    chk("R8 rx_ready back after read", {33'd0, rx_ready}, 34'd1);
    for (int i = 0; i < 15; i++) rx_check("R8 drain receive queue");
    rx_check("R7 empty receive queue read");

    // transmit overflow
    host_write(OFS_IEN, 32'd0);
    for (int i = 0; i < 17; i++) tx_send(16'h7000 + 16'(i), 16'h00C0 + 16'(i), i < 16);
    host_read(OFS_STAT, rd);
    chk("R4 overflow flag set", rd, 34'd1);
    host_write(OFS_TX - 6'h0C + 6'h08, 32'd0);
    host_read(OFS_STAT, rd);
    chk("R4 overflow flag sticky", rd, 34'd1);
    host_write(OFS_STAT, 32'd1);
    host_read(OFS_STAT, rd);
    chk("R4 overflow flag cleared", rd, 34'd0);

    // in-flight limit
    @(posedge clk); #1; tx_ready = 1;
    repeat (20) @(posedge clk);
    tx_send(16'h7F00, 16'h0077, 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 tx_valid held with full in-flight set", {33'd0, tx_valid}, 34'd0);
    for (int i = 0; i < 17; i++) begin
      complete(1'b0);
      cpl_check("R5 completion order after in-flight limit");
    end
    #1; tx_ready = 0;
    chk("R10 held request issued after completion", 34'(exp_tx.size()), 34'd0);

    finish_run();
  end
endmodule